// File: doc/BRIEF.md
# Capability Record Chain Walker

This block scans a chain of type-length-value capability records stored in a byte-addressed configuration space of fixed size (8 KB by default). After a start pulse it reads 32-bit words through a single-outstanding request/response memory port, decodes each 4-byte record header, and hops from record to record. It stops at an end record, on a malformed or unknown mandatory record, or when a record would leave the space.

Along the way it captures two capabilities. One is an engine clock frequency in MHz. The other is the location and size of a mailbox area, which replaces a built-in default location. When the walk stops, the block raises a done flag and holds it, together with a two-bit result code, until the next start. A start pulse that arrives while a walk is running is ignored.

The control is one state machine with these states:
- `S_IDLE`: after reset.
- `S_HDR_REQ`: issue a header read.
- `S_HDR_WAIT`: wait for the header word and decode it.
- `S_VAL_REQ`: issue a value read.
- `S_VAL_WAIT`: wait for the value word.
- `S_DONE`: finished.

Its transitions are:
- IDLE or DONE to HDR_REQ on start with a non-zero base.
- IDLE or DONE to DONE on start with a zero base.
- HDR_REQ to DONE when the header would be out of bounds.
- HDR_REQ to HDR_WAIT otherwise.
- HDR_WAIT to HDR_REQ for a skipped or mailbox record.
- HDR_WAIT to VAL_REQ for a clock record.
- HDR_WAIT to DONE for an end record or any error.
- VAL_REQ to VAL_WAIT.
- VAL_WAIT to HDR_REQ once the value arrives.

Top module: `cap_chain_walker`

## Requirements
- R1: A start with `base_off` equal to zero issues no read. `done` is high in the next cycle with `err_code` 0 and all capabilities at their defaults.
- R2: A header word carries the record type in bits 15:0 and the value length in bits 31:16. All reads are to 4-byte-aligned byte addresses. The next header is read at current address + 4 + length, because the length does not count the header.
- R3: Type code 2 ends the walk with `err_code` 0, and no further address is read.
- R4: A type whose low 15 bits are zero ends the walk with `err_code` 1.
- R5: Type 1 is skipped. Any unrecognised type with bit 15 clear is also skipped.
- R6: An unrecognised type with bit 15 set ends the walk with `err_code` 2.
- R7: For type 3, the word at address + 4 is read and presented on `clk_mhz`, with `clk_mhz_valid` set. A type-3 record of length 0 ends the walk with `err_code` 3.
- R8: For type 4, `mbox_off` becomes the record address + 4 and `mbox_len` becomes its length. A later type-4 record overrides an earlier one.
- R9: The walk ends with `err_code` 3 in any of these cases: a header at a misaligned address, a header ending past the space size, a length that is not a multiple of 4, or a record ending past the space size.
- R10: `done` and `err_code` hold until the next start. A start while `busy` is ignored. Each `mem_req` is a one-cycle pulse, and the next one waits for the response.
- R11: Reset and every accepted start restore the defaults: `mbox_off` 0x1800, `mbox_len` 504, `clk_mhz_valid` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| base_off | input | 13 | Byte offset of the first record, 0 = none |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 13 | Byte address of the read word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished, held until next start |
| err_code | output | 2 | 0 ok, 1 illegal type, 2 unknown required type, 3 bounds |
| clk_mhz | output | 32 | Captured clock frequency |
| clk_mhz_valid | output | 1 | Clock frequency captured |
| mbox_off | output | 14 | Mailbox byte offset |
| mbox_len | output | 16 | Mailbox byte length |

## Verification
A restart pulse and a memory response can reach the walker in the same cycle. The bench provokes this by repeating `start` while a walk is in flight, with response latencies of one to three cycles, so that the pulse lands on a wait state as data returns. The result is judged by comparing every issued read address, on the clock it appears, with the address sequence of a behavioural walk. The final codes and capabilities must also equal those of a walk started only once.

// File: rtl/cwalk_pkg.sv
package cwalk_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_HDR_REQ,
        S_HDR_WAIT,
        S_VAL_REQ,
        S_VAL_WAIT,
        S_DONE
    } walk_state_t;

    typedef enum logic [1:0] {
        ERR_NONE     = 2'd0,
        ERR_ILLEGAL  = 2'd1,
        ERR_REQUIRED = 2'd2,
        ERR_BOUNDS   = 2'd3
    } walk_err_t;

    typedef enum logic [2:0] {
        ACT_SKIP,
        ACT_END,
        ACT_ILLEGAL,
        ACT_REQUIRED,
        ACT_BOUNDS,
        ACT_FREQ,
        ACT_MBOX
    } hdr_act_t;

    localparam logic [14:0] TC_ILLEGAL = 15'd0;
    localparam logic [14:0] TC_PAD     = 15'd1;
    localparam logic [14:0] TC_END     = 15'd2;
    localparam logic [14:0] TC_FREQ    = 15'd3;
    localparam logic [14:0] TC_MBOX    = 15'd4;

endpackage

// File: rtl/cwalk_hdr_decode.sv
module cwalk_hdr_decode
    import cwalk_pkg::*;
#(
    parameter int SPACE_BYTES = 8192,
    parameter int OFF_W       = 14
) (
    input  logic [OFF_W-1:0] cur,
    input  logic [31:0]      hdr,
    output hdr_act_t         act,
    output logic [OFF_W-1:0] nxt,
    output logic [15:0]      len
);
    localparam int SUM_W = ((OFF_W > 16) ? OFF_W : 16) + 2;

    logic [14:0]      code;
    logic             req_bit;
    logic [SUM_W-1:0] rec_end;

    always_comb begin
        code    = hdr[14:0];
        req_bit = hdr[15];
        len     = hdr[31:16];
        rec_end = SUM_W'(cur) + SUM_W'(4) + SUM_W'(len);
        nxt     = rec_end[OFF_W-1:0];
        if (code == TC_ILLEGAL)
            act = ACT_ILLEGAL;
        else if (code == TC_END)
            act = ACT_END;
        else if (len[1:0] != 2'b00 || rec_end > SUM_W'(SPACE_BYTES))
            act = ACT_BOUNDS;
        else if (code == TC_FREQ)
            act = (len == 16'd0) ? ACT_BOUNDS : ACT_FREQ;
        else if (code == TC_MBOX)
            act = ACT_MBOX;
        else if (code == TC_PAD)
            act = ACT_SKIP;
        else if (req_bit)
            act = ACT_REQUIRED;
        else
            act = ACT_SKIP;
    end
endmodule

// File: rtl/cwalk_cap_regs.sv
module cwalk_cap_regs #(
    parameter int OFF_W        = 14,
    parameter int DEF_MBOX_OFF = 32'h1800,
    parameter int DEF_MBOX_LEN = 504
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             freq_we,
    input  logic [31:0]      freq_in,
    input  logic             mbox_we,
    input  logic [OFF_W-1:0] mbox_off_in,
    input  logic [15:0]      mbox_len_in,
    output logic [31:0]      clk_mhz,
    output logic             clk_mhz_valid,
    output logic [OFF_W-1:0] mbox_off,
    output logic [15:0]      mbox_len
);
    localparam logic [OFF_W-1:0] DEF_OFF = OFF_W'(DEF_MBOX_OFF);
    localparam logic [15:0]      DEF_LEN = 16'(DEF_MBOX_LEN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_mhz       <= '0;
            clk_mhz_valid <= 1'b0;
            mbox_off      <= DEF_OFF;
            mbox_len      <= DEF_LEN;
        end else if (clear) begin
            clk_mhz       <= '0;
            clk_mhz_valid <= 1'b0;
            mbox_off      <= DEF_OFF;
            mbox_len      <= DEF_LEN;
        end else begin
            if (freq_we) begin
                clk_mhz       <= freq_in;
                clk_mhz_valid <= 1'b1;
            end
            if (mbox_we) begin
                mbox_off <= mbox_off_in;
                mbox_len <= mbox_len_in;
            end
        end
    end

    // R11: an accepted start brings every capability back to its default
    p_defaults_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (mbox_off == DEF_OFF && mbox_len == DEF_LEN && !clk_mhz_valid));

    // R8: a mailbox write lands on the outputs one cycle later
    p_mbox_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_we && !clear) |=> (mbox_off == $past(mbox_off_in) && mbox_len == $past(mbox_len_in)));
endmodule

// File: rtl/cap_chain_walker.sv
module cap_chain_walker
    import cwalk_pkg::*;
#(
    parameter int SPACE_BYTES  = 8192,
    parameter int DEF_MBOX_OFF = 32'h1800,
    parameter int DEF_MBOX_LEN = 504,
    localparam int AW          = $clog2(SPACE_BYTES),
    localparam int OFF_W       = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [AW-1:0]    base_off,
    output logic             mem_req,
    output logic [AW-1:0]    mem_addr,
    input  logic             mem_rsp_valid,
    input  logic [31:0]      mem_rsp_data,
    output logic             busy,
    output logic             done,
    output logic [1:0]       err_code,
    output logic [31:0]      clk_mhz,
    output logic             clk_mhz_valid,
    output logic [OFF_W-1:0] mbox_off,
    output logic [15:0]      mbox_len
);
    walk_state_t      state_q, state_d;
    walk_err_t        err_q, err_d;
    logic [OFF_W-1:0] cur_q, cur_d, nxt_q, nxt_d;
    logic [OFF_W-1:0] val_addr;
    logic [OFF_W:0]   hdr_end;
    logic             hdr_oob;
    logic             cap_clear, freq_we, mbox_we;
    hdr_act_t         act;
    logic [OFF_W-1:0] dec_nxt;
    logic [15:0]      dec_len;

    cwalk_hdr_decode #(.SPACE_BYTES(SPACE_BYTES), .OFF_W(OFF_W)) u_dec (
        .cur (cur_q),
        .hdr (mem_rsp_data),
        .act (act),
        .nxt (dec_nxt),
        .len (dec_len)
    );

    cwalk_cap_regs #(.OFF_W(OFF_W), .DEF_MBOX_OFF(DEF_MBOX_OFF),
                     .DEF_MBOX_LEN(DEF_MBOX_LEN)) u_caps (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (cap_clear),
        .freq_we       (freq_we),
        .freq_in       (mem_rsp_data),
        .mbox_we       (mbox_we),
        .mbox_off_in   (val_addr),
        .mbox_len_in   (dec_len),
        .clk_mhz       (clk_mhz),
        .clk_mhz_valid (clk_mhz_valid),
        .mbox_off      (mbox_off),
        .mbox_len      (mbox_len)
    );

    always_comb begin
        val_addr = cur_q + OFF_W'(4);
        hdr_end  = {1'b0, cur_q} + (OFF_W+1)'(4);
        hdr_oob  = (cur_q[1:0] != 2'b00) || (hdr_end > (OFF_W+1)'(SPACE_BYTES));
    end

    // next-state and datapath
    always_comb begin
        state_d   = state_q;
        err_d     = err_q;
        cur_d     = cur_q;
        nxt_d     = nxt_q;
        cap_clear = 1'b0;
        freq_we   = 1'b0;
        mbox_we   = 1'b0;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (start) begin
                    cap_clear = 1'b1;
                    err_d     = ERR_NONE;
                    cur_d     = OFF_W'(base_off);
                    state_d   = (base_off == '0) ? S_DONE : S_HDR_REQ;
                end
            end
            S_HDR_REQ: begin
                if (hdr_oob) begin
                    err_d   = ERR_BOUNDS;
                    state_d = S_DONE;
                end else begin
                    state_d = S_HDR_WAIT;
                end
            end
            S_HDR_WAIT: begin
                if (mem_rsp_valid) begin
                    unique case (act)
                        ACT_END:      state_d = S_DONE;
                        ACT_ILLEGAL:  begin err_d = ERR_ILLEGAL;  state_d = S_DONE; end
                        ACT_REQUIRED: begin err_d = ERR_REQUIRED; state_d = S_DONE; end
                        ACT_BOUNDS:   begin err_d = ERR_BOUNDS;   state_d = S_DONE; end
                        ACT_FREQ:     begin nxt_d = dec_nxt; state_d = S_VAL_REQ; end
                        ACT_MBOX: begin
                            mbox_we = 1'b1;
                            cur_d   = dec_nxt;
                            state_d = S_HDR_REQ;
                        end
                        default: begin
                            cur_d   = dec_nxt;
                            state_d = S_HDR_REQ;
                        end
                    endcase
                end
            end
            S_VAL_REQ: state_d = S_VAL_WAIT;
            S_VAL_WAIT: begin
                if (mem_rsp_valid) begin
                    freq_we = 1'b1;
                    cur_d   = nxt_q;
                    state_d = S_HDR_REQ;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            err_q   <= ERR_NONE;
            cur_q   <= '0;
            nxt_q   <= '0;
        end else begin
            state_q <= state_d;
            err_q   <= err_d;
            cur_q   <= cur_d;
            nxt_q   <= nxt_d;
        end
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = cur_q[AW-1:0];
        busy     = 1'b0;
        done     = 1'b0;
        err_code = err_q;
        unique case (state_q)
            S_HDR_REQ:  begin busy = 1'b1; mem_req = !hdr_oob; end
            S_HDR_WAIT: busy = 1'b1;
            S_VAL_REQ:  begin busy = 1'b1; mem_req = 1'b1; mem_addr = val_addr[AW-1:0]; end
            S_VAL_WAIT: busy = 1'b1;
            S_DONE:     done = 1'b1;
            default:    ;
        endcase
    end

    // R10: one request at a time, each a single-cycle pulse
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R10: finished state and result stay put until a new start
    p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(err_code)));

    // R1: an empty chain finishes on the next cycle without error
    p_zero_base_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && base_off == '0) |=> (done && err_code == 2'd0 && !mem_req));

    // R2: every read is word aligned
    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R10: a start while busy does not disturb the walk result code
    p_err_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (err_code == 2'd0));
endmodule

// File: tb/cap_chain_walker_tb.sv
module cap_chain_walker_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] base_off = '0;
    logic        mem_req;
    logic [12:0] mem_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        busy, done, clk_mhz_valid;
    logic [1:0]  err_code;
    logic [31:0] clk_mhz;
    logic [13:0] mbox_off;
    logic [15:0] mbox_len;

    int n_chk = 0;
    int n_bad = 0;
    int lat   = 1;
    int cyc   = 0;

    logic [31:0] mem [0:2047];
    int addr_q[$];
    int exp_err, exp_fv, exp_freq, exp_mo, exp_ml;

    cap_chain_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_off(base_off),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .busy(busy), .done(done), .err_code(err_code),
        .clk_mhz(clk_mhz), .clk_mhz_valid(clk_mhz_valid),
        .mbox_off(mbox_off), .mbox_len(mbox_len)
    );

    always #4 clk = ~clk;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                finish_run();
            end
        end
    end

    // memory responder and per-clock address comparison (R2, R3, R10)
    initial begin
        int cnt;
        int raddr;
        cnt = 0;
        raddr = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    mem_rsp_valid = 1'b1;
                    mem_rsp_data  = mem[raddr >> 2];
                end
            end
            if (mem_req) begin
                if (addr_q.size() == 0)
                    chk("R3 unexpected read", int'(mem_addr), -1);
                else
                    chk("R2 read address", int'(mem_addr), addr_q.pop_front());
                raddr = int'(mem_addr);
                cnt   = lat;
            end
        end
    end

    function automatic void put(int addr, int typ, int len);
        mem[addr >> 2] = {16'(len), 16'(typ)};
    endfunction

    // behavioural walk of the record chain
    function automatic void model(int base);
        int cur, w, t, len, code;
        addr_q.delete();
        exp_err = 0; exp_fv = 0; exp_freq = 0; exp_mo = 'h1800; exp_ml = 504;
        if (base == 0) return;
        cur = base;
        forever begin
            if (cur % 4 != 0 || cur + 4 > 8192) begin exp_err = 3; return; end
            addr_q.push_back(cur);
            w = int'(mem[cur >> 2]);
            t = w & 'hffff;
            len = (w >> 16) & 'hffff;
            code = t & 'h7fff;
            if (code == 0) begin exp_err = 1; return; end
            if (code == 2) return;
            if (len % 4 != 0 || cur + 4 + len > 8192) begin exp_err = 3; return; end
            if (code == 3) begin
                if (len == 0) begin exp_err = 3; return; end
                addr_q.push_back(cur + 4);
                exp_freq = int'(mem[(cur + 4) >> 2]);
                exp_fv = 1;
            end else if (code == 4) begin
                exp_mo = cur + 4;
                exp_ml = len;
            end else if (code != 1 && (t & 'h8000) != 0) begin
                exp_err = 2; return;
            end
            cur = cur + 4 + len;
        end
    endfunction

    task automatic run_walk(string tag, int base, int l, bit dup);
        int n;
        lat = l;
        model(base);
        @(negedge clk);
        base_off = 13'(base);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (dup) begin
            repeat (2) @(negedge clk);
            start = 1'b1;   // ignored while busy (R10)
            @(negedge clk);
            start = 1'b0;
        end
        n = 0;
        while (!done && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done"}, int'(done), 1);
        chk({tag, " err_code"}, int'(err_code), exp_err);
        chk({tag, " clk_mhz_valid"}, int'(clk_mhz_valid), exp_fv);
        if (exp_fv != 0) chk({tag, " clk_mhz"}, int'(clk_mhz), exp_freq);
        chk({tag, " mbox_off"}, int'(mbox_off), exp_mo);
        chk({tag, " mbox_len"}, int'(mbox_len), exp_ml);
        chk({tag, " reads left"}, addr_q.size(), 0);
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11 reset done", int'(done), 0);
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset mem_req", int'(mem_req), 0);
        chk("R11 reset mbox_off", int'(mbox_off), 'h1800);
        chk("R11 reset mbox_len", int'(mbox_len), 504);
        chk("R11 reset clk valid", int'(clk_mhz_valid), 0);

        // R1: empty chain, done on the following cycle
        lat = 1;
        model(0);
        base_off = '0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R1 immediate done", int'(done), 1);
        chk("R1 err", int'(err_code), 0);
        chk("R1 mbox_off default", int'(mbox_off), 'h1800);

        // R2 R3 R5 R7 R8: full chain
        put('h58, 3, 4);  mem['h5C >> 2] = 32'd1200;
        put('h60, 1, 8);
        put('h6C, 4, 'h40);
        put('hB0, 'h0020, 4);
        put('hB8, 2, 'h10);
        put('hBC, 3, 4);
        run_walk("R2_R3_R5_R7_R8 chain", 'h58, 1, 1'b0);
        // R10: result holds
        repeat (5) @(negedge clk);
        chk("R10 done held", int'(done), 1);
        chk("R10 err held", int'(err_code), 0);

        // R4 with R11 defaults restored after earlier override
        put('h100, 1, 0);
        put('h104, 'h8000, 4);
        run_walk("R4_R11 illegal", 'h100, 2, 1'b0);

        // R6: unknown required type after a clock record
        put('h200, 3, 4); mem['h204 >> 2] = 32'd800;
        put('h208, 'h8021, 4);
        run_walk("R6 required", 'h200, 3, 1'b0);

        // R9: length not a multiple of 4
        put('h300, 1, 6);
        run_walk("R9 odd length", 'h300, 1, 1'b0);

        // R9: record end past the space
        put('h1FF0, 1, 'h20);
        run_walk("R9 record overrun", 'h1FF0, 2, 1'b0);

        // R9 R8: header past the space after a zero-length mailbox at the edge
        put('h1FF8, 1, 0);
        put('h1FFC, 4, 0);
        run_walk("R9_R8 header overrun", 'h1FF8, 1, 1'b0);

        // R8 override then R7 zero-length clock record
        put('h400, 4, 8);
        put('h40C, 4, 'h10);
        put('h420, 3, 0);
        run_walk("R8_R7 override", 'h400, 2, 1'b0);

        // R9: misaligned base
        run_walk("R9 misaligned", 'h402, 1, 1'b0);

        // R10: restart pulses while busy, all latencies
        for (int l = 1; l <= 3; l++)
            run_walk("R10 dup start", 'h58, l, 1'b1);

        finish_run();
    end
endmodule